// File: doc/BRIEF.md
# Floating-Point Predicate Comparator

This block compares two IEEE-754 single-precision operands under one of seven predicates and returns a one-bit answer together with an invalid-operation flag. The predicates are equal, less-than, less-or-equal, unordered, and three unordered-inclusive forms: unordered-or-equal, unordered-or-less-than and unordered-or-less-or-equal. Zeros of either sign, infinities, denormals and NaNs are handled.

The two relational predicates (less-than and less-or-equal) use signaling semantics. Any NaN operand raises invalid. Equality, unordered and the three unordered-inclusive predicates use quiet semantics. For those, only a signaling NaN raises invalid. A request is presented with `in_valid`. The answer appears one clock later, qualified by `out_valid`. The invalid flag is meant to be OR-ed into a separate status register outside this block.

The operand format is parameterised by exponent and fraction width. A parameter also selects how the magnitude compare is built.

Top module: `fp_predicate_cmp`

## Requirements
- R1: Predicate code 0 (equal) gives 1 when the operands have equal value, so +0 equals -0. It gives 0 if either operand is a NaN, and it raises invalid only when an operand is a signaling NaN.
- R2: Predicate code 1 (less-than) gives 1 when a < b. If either operand is any NaN it gives 0 and raises invalid.
- R3: Predicate code 2 (less-or-equal) gives 1 when a <= b. If either operand is any NaN it gives 0 and raises invalid.
- R4: Predicate code 3 (unordered) gives 1 exactly when at least one operand is a NaN. It raises invalid only for a signaling NaN.
- R5: Predicate code 4 (unordered-or-equal) gives 1 when a == b or when either operand is a NaN. It raises invalid only for a signaling NaN.
- R6: Predicate code 5 (unordered-or-less-than) gives 1 when a < b or when either operand is a NaN. It raises invalid only for a signaling NaN.
- R7: Predicate code 6 (unordered-or-less-or-equal) gives 1 unless a > b, so any NaN operand gives 1. It raises invalid only for a signaling NaN.
- R8: A NaN has an all-ones exponent (bits 30:23) and a non-zero fraction (bits 22:0). It is signaling when fraction bit 22 is 0 and quiet when that bit is 1. Bit 31 is the sign.
- R9: Predicate code 7 gives result 0 and invalid 0 for any operands.
- R10: `out_valid` equals `in_valid` delayed by one clock. The `result` and `invalid` outputs belong to the request accepted on that edge. Whenever `out_valid` is 0, both outputs are 0.
- R11: While reset is asserted, and after it is released until the first request, `out_valid`, `result` and `invalid` are 0.
- R12: Non-NaN values are ordered by numeric value: denormals, normals and infinities of both signs, with every negative value below every positive value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe for the operands and the predicate |
| op_a | input | 32 | Left operand a |
| op_b | input | 32 | Right operand b |
| pred_sel | input | 3 | Predicate code 0 to 7 |
| out_valid | output | 1 | Answer strobe, one cycle after in_valid |
| result | output | 1 | Predicate outcome |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The hardest case to reach from the ports is a pair of non-NaN operands whose encodings differ only in their low fraction bits, compared under every predicate. Uniformly random 32-bit words almost never produce such pairs, and almost never produce signaling NaNs against quiet NaNs. The stimulus therefore builds each operand from a randomly chosen class: zero, denormal, normal, infinity, quiet NaN, signaling NaN, a copy of the other operand, its negation, or a one-ulp neighbour of it. Directed cases add the signed-zero pair, the two infinities, and the reserved predicate code.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

   typedef enum logic [2:0] {
      PRED_EQ  = 3'd0,
      PRED_LT  = 3'd1,
      PRED_LE  = 3'd2,
      PRED_UN  = 3'd3,
      PRED_UEQ = 3'd4,
      PRED_ULT = 3'd5,
      PRED_ULE = 3'd6,
      PRED_RSV = 3'd7
   } pred_e;

   typedef struct packed {
      logic sign;
      logic is_zero;
      logic is_nan;
      logic is_snan;
   } opclass_t;

   typedef struct packed {
      logic lt;
      logic eq;
      logic gt;
      logic un;
   } rel_t;

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
   import fpcmp_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int WORD_W = 1 + EXP_W + MAN_W
) (
   input  logic [WORD_W-1:0] op,
   output opclass_t          cls,
   output logic [WORD_W-2:0] mag
);
   logic [EXP_W-1:0] expo;
   logic [MAN_W-1:0] frac;
   logic             exp_all_ones;
   logic             frac_nonzero;

   assign expo         = op[WORD_W-2:MAN_W];
   assign frac         = op[MAN_W-1:0];
   assign exp_all_ones = &expo;
   assign frac_nonzero = |frac;
   assign mag          = op[WORD_W-2:0];

   always_comb begin
      cls.sign    = op[WORD_W-1];
      cls.is_zero = ~|op[WORD_W-2:0];
      cls.is_nan  = exp_all_ones & frac_nonzero;
      cls.is_snan = exp_all_ones & frac_nonzero & ~frac[MAN_W-1];
   end
endmodule

// File: rtl/fpcmp_relate.sv
module fpcmp_relate
   import fpcmp_pkg::*;
#(
   parameter int EXP_W     = 8,
   parameter int MAN_W     = 23,
   parameter bit SPLIT_CMP = 1'b1,
   localparam int MAG_W    = EXP_W + MAN_W
) (
   input  opclass_t         cls_a,
   input  opclass_t         cls_b,
   input  logic [MAG_W-1:0] mag_a,
   input  logic [MAG_W-1:0] mag_b,
   output rel_t             rel
);
   logic mag_lt;
   logic mag_eq;

   generate
      if (SPLIT_CMP) begin : g_split
         logic [EXP_W-1:0] ea, eb;
         logic [MAN_W-1:0] fa, fb;
         logic             e_lt, e_eq, f_lt, f_eq;
         assign ea   = mag_a[MAG_W-1:MAN_W];
         assign eb   = mag_b[MAG_W-1:MAN_W];
         assign fa   = mag_a[MAN_W-1:0];
         assign fb   = mag_b[MAN_W-1:0];
         assign e_lt = ea < eb;
         assign e_eq = ea == eb;
         assign f_lt = fa < fb;
         assign f_eq = fa == fb;
         assign mag_lt = e_lt | (e_eq & f_lt);
         assign mag_eq = e_eq & f_eq;
      end else begin : g_flat
         assign mag_lt = mag_a < mag_b;
         assign mag_eq = mag_a == mag_b;
      end
   endgenerate

   always_comb begin
      rel = '0;
      if (cls_a.is_nan || cls_b.is_nan) begin
         rel.un = 1'b1;
      end else if (cls_a.is_zero && cls_b.is_zero) begin
         rel.eq = 1'b1;
      end else if (cls_a.sign != cls_b.sign) begin
         rel.lt = cls_a.sign;
         rel.gt = cls_b.sign;
      end else if (mag_eq) begin
         rel.eq = 1'b1;
      end else if (!cls_a.sign) begin
         rel.lt = mag_lt;
         rel.gt = ~mag_lt;
      end else begin
         rel.lt = ~mag_lt;
         rel.gt = mag_lt;
      end
   end
endmodule

// File: rtl/fpcmp_select.sv
module fpcmp_select
   import fpcmp_pkg::*;
(
   input  pred_e pred,
   input  rel_t  rel,
   input  logic  any_snan,
   output logic  res,
   output logic  inv
);
   always_comb begin
      res = 1'b0;
      inv = 1'b0;
      unique case (pred)
         PRED_EQ:  begin res = rel.eq;                   inv = any_snan; end
         PRED_LT:  begin res = rel.lt;                   inv = rel.un;   end
         PRED_LE:  begin res = rel.lt | rel.eq;          inv = rel.un;   end
         PRED_UN:  begin res = rel.un;                   inv = any_snan; end
         PRED_UEQ: begin res = rel.eq | rel.un;          inv = any_snan; end
         PRED_ULT: begin res = rel.lt | rel.un;          inv = any_snan; end
         PRED_ULE: begin res = ~rel.gt;                  inv = any_snan; end
         PRED_RSV: begin res = 1'b0;                     inv = 1'b0;     end
         default:  begin res = 1'b0;                     inv = 1'b0;     end
      endcase
   end
endmodule

// File: rtl/fp_predicate_cmp.sv
module fp_predicate_cmp
   import fpcmp_pkg::*;
#(
   parameter int EXP_W     = 8,
   parameter int MAN_W     = 23,
   parameter int SEL_W     = 3,
   parameter bit SPLIT_CMP = 1'b1,
   localparam int WORD_W   = 1 + EXP_W + MAN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] op_a,
   input  logic [WORD_W-1:0] op_b,
   input  logic [SEL_W-1:0]  pred_sel,
   output logic              out_valid,
   output logic              result,
   output logic              invalid
);
   localparam int MAG_W = WORD_W - 1;

   generate
      if (EXP_W < 2) begin : g_bad_exp
         $error("fp_predicate_cmp: EXP_W must be at least 2");
      end
      if (MAN_W < 2) begin : g_bad_man
         $error("fp_predicate_cmp: MAN_W must be at least 2");
      end
      if (SEL_W != 3) begin : g_bad_sel
         $error("fp_predicate_cmp: SEL_W must be 3");
      end
   endgenerate

   opclass_t             cls [2];
   logic     [MAG_W-1:0] mag [2];
   logic     [WORD_W-1:0] opnd [2];

   assign opnd[0] = op_a;
   assign opnd[1] = op_b;

   generate
      for (genvar i = 0; i < 2; i++) begin : g_cls
         fpcmp_classify #(
            .EXP_W (EXP_W),
            .MAN_W (MAN_W)
         ) u_cls (
            .op  (opnd[i]),
            .cls (cls[i]),
            .mag (mag[i])
         );
      end
   endgenerate

   rel_t rel;

   fpcmp_relate #(
      .EXP_W     (EXP_W),
      .MAN_W     (MAN_W),
      .SPLIT_CMP (SPLIT_CMP)
   ) u_rel (
      .cls_a (cls[0]),
      .cls_b (cls[1]),
      .mag_a (mag[0]),
      .mag_b (mag[1]),
      .rel   (rel)
   );

   logic any_snan;
   logic res_c;
   logic inv_c;

   assign any_snan = cls[0].is_snan | cls[1].is_snan;

   fpcmp_select u_sel (
      .pred     (pred_e'(pred_sel)),
      .rel      (rel),
      .any_snan (any_snan),
      .res      (res_c),
      .inv      (inv_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= 1'b0;
         invalid   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         result    <= in_valid & res_c;
         invalid   <= in_valid & inv_c;
      end
   end
endmodule

module fp_predicate_cmp_chk #(
   parameter int WORD_W = 32,
   parameter int MAN_W  = 23
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [WORD_W-1:0] op_a,
   input logic [WORD_W-1:0] op_b,
   input logic [2:0]        pred_sel,
   input logic              out_valid,
   input logic              result,
   input logic              invalid
);
   logic a_nan, b_nan, any_nan;
   assign a_nan   = (&op_a[WORD_W-2:MAN_W]) && (|op_a[MAN_W-1:0]);
   assign b_nan   = (&op_b[WORD_W-2:MAN_W]) && (|op_b[MAN_W-1:0]);
   assign any_nan = a_nan | b_nan;

   // R10
   valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R10
   valid_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!result && !invalid));
   // R9
   reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && pred_sel == 3'd7) |=> (!result && !invalid));
   // R2
   lt_nan_signals_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && pred_sel == 3'd1 && any_nan) |=> (!result && invalid));
   // R3
   le_nan_signals_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && pred_sel == 3'd2 && any_nan) |=> (!result && invalid));
   // R4
   un_matches_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && pred_sel == 3'd3) |=> (result == $past(any_nan)));
   // R7
   ule_nan_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && pred_sel == 3'd6 && any_nan) |=> result);
   // R1
   eq_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && pred_sel == 3'd0 && op_a == op_b && !any_nan) |=> (result && !invalid));
endmodule

bind fp_predicate_cmp fp_predicate_cmp_chk #(
   .WORD_W (WORD_W),
   .MAN_W  (MAN_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op_a      (op_a),
   .op_b      (op_b),
   .pred_sel  (pred_sel),
   .out_valid (out_valid),
   .result    (result),
   .invalid   (invalid)
);

// File: tb/fp_predicate_cmp_tb.sv
module fp_predicate_cmp_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic [2:0]  pred_sel = '0;
   logic        out_valid, result, invalid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   fp_predicate_cmp u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .op_a(op_a), .op_b(op_b), .pred_sel(pred_sel),
      .out_valid(out_valid), .result(result), .invalid(invalid)
   );

   function automatic bit is_nan(logic [31:0] x);
      return (x[30:23] == 8'hFF) && (x[22:0] != 0);
   endfunction
   function automatic bit is_snan(logic [31:0] x);
      return is_nan(x) && !x[22];
   endfunction
   // R12: signed ordering key, both zeros map to 0
   function automatic longint key(logic [31:0] x);
      longint m = longint'(x[30:0]);
      return x[31] ? -m : m;
   endfunction

   function automatic string req_of(logic [2:0] p);
      case (p)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R4";
         3'd4: return "R5";
         3'd5: return "R6";
         3'd6: return "R7";
         default: return "R9";
      endcase
   endfunction

   function automatic void expect_of(logic [31:0] a, logic [31:0] b, logic [2:0] p,
                                     output bit r, output bit f);
      bit un  = is_nan(a) || is_nan(b);
      bit sn  = is_snan(a) || is_snan(b);
      bit lt  = !un && key(a) < key(b);
      bit eq  = !un && key(a) == key(b);
      bit gt  = !un && key(a) > key(b);
      case (p)
         3'd0: begin r = eq;       f = sn; end
         3'd1: begin r = lt;       f = un; end
         3'd2: begin r = lt || eq; f = un; end
         3'd3: begin r = un;       f = sn; end
         3'd4: begin r = eq || un; f = sn; end
         3'd5: begin r = lt || un; f = sn; end
         3'd6: begin r = !gt;      f = sn; end
         default: begin r = 1'b0;  f = 1'b0; end
      endcase
   endfunction

   task automatic check(string req, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
      end
   endtask

   task automatic apply(logic [31:0] a, logic [31:0] b, logic [2:0] p);
      bit er, ef;
      @(negedge clk);
      op_a = a; op_b = b; pred_sel = p; in_valid = 1'b1;
      expect_of(a, b, p, er, ef);
      @(negedge clk);
      in_valid = 1'b0;
      check("R10", "out_valid", out_valid, 1'b1);
      check(req_of(p), $sformatf("result a=%h b=%h p=%0d", a, b, p), result, er);
      check(req_of(p), $sformatf("invalid a=%h b=%h p=%0d", a, b, p), invalid, ef);
   endtask

   // R8: operand classes built from the field layout
   function automatic logic [31:0] gen(logic [31:0] other);
      logic [31:0] x = $urandom;
      case ($urandom_range(0, 9))
         0: x = {x[31], 31'd0};
         1: x = {x[31], 8'd0, x[22:0]};
         2: x = {x[31], 8'hFF, 23'd0};
         3: x = {x[31], 8'hFF, 1'b1, x[21:0]};
         4: x = {x[31], 8'hFF, 1'b0, x[21:1], 1'b1};
         5: x = other;
         6: x = {~other[31], other[30:0]};
         7: x = other + 32'd1;
         8: x = other - 32'd1;
         default: ;
      endcase
      return x;
   endfunction

   initial begin
      void'($urandom(32'd20250611));
      repeat (3) @(negedge clk);
      // R11
      check("R11", "out_valid in reset", out_valid, 1'b0);
      check("R11", "result in reset", result, 1'b0);
      check("R11", "invalid in reset", invalid, 1'b0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check("R11", "out_valid after reset", out_valid, 1'b0);

      // R1: signed zeros equal
      apply(32'h0000_0000, 32'h8000_0000, 3'd0);
      // R1: quiet NaN gives no flag
      apply(32'h7FC0_0000, 32'h3F80_0000, 3'd0);
      // R1: signaling NaN flags
      apply(32'h7F80_0001, 32'h3F80_0000, 3'd0);
      // R2 / R3: quiet NaN still signals
      apply(32'h7FC0_0000, 32'h0000_0000, 3'd1);
      apply(32'h0000_0000, 32'hFFC0_0000, 3'd2);
      // R12: infinities and denormals
      apply(32'hFF80_0000, 32'h7F80_0000, 3'd1);
      apply(32'h8000_0001, 32'h0000_0001, 3'd1);
      apply(32'h0000_0002, 32'h0000_0001, 3'd2);
      // R4..R7 with NaN and ordered inputs
      apply(32'h7FC0_0000, 32'h7FC0_0000, 3'd3);
      apply(32'h3F80_0000, 32'h3F80_0000, 3'd4);
      apply(32'hBF80_0000, 32'h3F80_0000, 3'd5);
      apply(32'h4000_0000, 32'h3F80_0000, 3'd6);
      apply(32'h7F80_0001, 32'h3F80_0000, 3'd6);
      // R9: reserved code with a signaling NaN
      apply(32'h7F80_0001, 32'h7F80_0001, 3'd7);
      // R10: idle cycle keeps outputs low
      @(negedge clk);
      check("R10", "idle out_valid", out_valid, 1'b0);
      check("R10", "idle result", result, 1'b0);

      for (int i = 0; i < 4000; i++) begin
         logic [31:0] a = gen($urandom);
         logic [31:0] b = gen(a);
         apply(a, b, 3'($urandom_range(0, 7)));
      end
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule